// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a synthesizable behavioural model of a byte-wide memory whose cells can only be programmed once. Each cell starts in the erased state, all ones. Programming can only pull bits from one to zero. The model has a 17-bit address, a data bus split into `din`, `dout` and a drive enable `dout_en`, and three active-low controls: chip select, output enable and program strobe. Two level inputs stand for electrical conditions. `vpp_hi` means the programming supply is raised. `id_hv` means the identifier overvoltage is present on address line 9.

A combinational decoder turns the control levels into one operating mode: read, output disable, standby, program, program verify, program inhibit or identifier. Reads and verifies are combinational from the address. A program operation takes effect at the rising clock edge while the program mode is decoded. The stored byte becomes the bitwise AND of its old value and `din`. By default the storage holds 2^`STORE_AW` bytes. Wider addresses are folded onto it by XOR, and setting `STORE_AW` equal to `ADDR_W` gives the full 131072-byte array.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=0 and `id_hv`=0, `dout_en` is 1 and `dout` is the byte stored at `addr`.
- R3: With `ce_n`=1, `dout_en` is 0 whatever the other inputs are, and no location is written, even with `vpp_hi`=1 and `pgm_n`=0.
- R4: With `ce_n`=0, `oe_n`=1 and `pgm_n`=1, `dout_en` is 0.
- R5: With `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0, a rising clock edge writes the addressed location, and `dout_en` is 0 while this mode holds.
- R6: A write stores (old AND `din`), so no write can ever turn a 0 bit back into 1.
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, `dout_en` is 1 and `dout` is the stored byte.
- R8: In read mode with `id_hv`=1, `dout` is 0x07 when `addr[0]`=0 and 0x38 when `addr[0]`=1. The stored array is not returned and not changed.
- R9: `pgm_n`=0 with `vpp_hi`=0 writes nothing and gives `dout_en`=0.
- R10: With `vpp_hi`=1, `ce_n`=0 and both `oe_n` and `pgm_n` low, nothing is written and `dout_en` is 0.
- R11: Whenever `dout_en` is 0, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset, returns every cell to 0xFF |
| addr | input | 17 | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte driven onto the bus |
| dout_en | output | 1 | High when the model drives the bus |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identifier overvoltage present on address line 9 |

## Verification
The checker watches several rules on every cycle:
- the bus is silent whenever chip select is high;
- `dout` is zero when not driven;
- identifier reads return only the two fixed bytes, chosen by address bit 0;
- a steady read of one address stays stable;
- two consecutive verifies of the same address never show a bit rising from 0 to 1;
- the write strobe is only active under the program combination.

Only the bench scenarios show the AND result of repeated writes and the absence of writes under the inhibit and conflicting combinations. They also show that identifier mode neither reads nor disturbs the stored byte at the same address, and that reset restores the erased state.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    M_STANDBY, M_INHIBIT, M_READ, M_IDENT, M_QUIET, M_PROG, M_VERIFY
  } otp_mode_e;

  localparam logic [7:0] ID_MAKER  = 8'h07;
  localparam logic [7:0] ID_DEVICE = 8'h38;
  localparam logic [7:0] ERASED    = 8'hFF;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vpp_hi,
  input  logic      id_hv,
  output otp_mode_e mode
);
  always_comb begin
    mode = M_QUIET;
    if (ce_n) begin
      mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    end else if (vpp_hi) begin
      unique case ({oe_n, pgm_n})
        2'b10:   mode = M_PROG;
        2'b01:   mode = M_VERIFY;
        default: mode = M_QUIET;
      endcase
    end else if (!oe_n && pgm_n) begin
      mode = id_hv ? M_IDENT : M_READ;
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    cells [DEPTH];
  logic [DEPTH-1:0] burnt;

  assign rdata = burnt[idx] ? cells[idx] : {DW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burnt <= '0;
    else if (wr_en) burnt[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= rdata & wdata;
  end
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv
);
  otp_mode_e           mode;
  logic [STORE_AW-1:0] idx;
  logic                wr_en;
  logic [DATA_W-1:0]   cell_q;
  logic [DATA_W-1:0]   id_byte;

  otp_mode_dec u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .mode(mode)
  );

  always_comb begin
    idx = '0;
    for (int i = 0; i < ADDR_W; i++) idx[i % STORE_AW] = idx[i % STORE_AW] ^ addr[i];
  end

  assign wr_en = (mode == M_PROG);

  otp_cell_array #(.AW(STORE_AW), .DW(DATA_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en),
    .wdata(din), .rdata(cell_q)
  );

  assign id_byte = addr[0] ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER);

  always_comb begin
    dout_en = 1'b0;
    dout    = '0;
    unique case (mode)
      M_READ, M_VERIFY: begin dout_en = 1'b1; dout = cell_q; end
      M_IDENT:          begin dout_en = 1'b1; dout = id_byte; end
      default:          ;
    endcase
  end
endmodule

// File: rtl/otp_byte_mem_chk.sv
module otp_byte_mem_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              id_hv,
  input logic              wr_en
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  wire rd_c  = !ce_n && !oe_n && pgm_n && !vpp_hi && !id_hv;
  wire vf_c  = !ce_n && !oe_n && pgm_n && vpp_hi;
  wire idr_c = !ce_n && !oe_n && pgm_n && !vpp_hi && id_hv;

  p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en && !wr_en);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);

  p_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> vpp_hi && !ce_n && oe_n && !pgm_n);

  p_id_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idr_c |-> dout_en && dout == (addr[0] ? DATA_W'(8'h38) : DATA_W'(8'h07)));

  p_read_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rd_c && $past(rd_c) && $stable(addr)) |-> $stable(dout) && dout_en);

  p_no_new_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && vf_c && $past(vf_c) && $stable(addr)) |-> (dout & ~$past(dout)) == '0);
endmodule

bind otp_byte_mem otp_byte_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .dout(dout), .dout_en(dout_en),
  .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi), .id_hv(id_hv),
  .wr_en(wr_en)
);

// File: tb/otp_byte_mem_bench.sv
module otp_byte_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_byte_mem u_otp_byte_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv)
  );

  // {ce_n,oe_n,pgm_n,vpp_hi,id_hv}, addr, din, expected en, expected dout
  localparam logic [38:0] VEC [NV] = '{
    {5'b00100, 17'h00005, 8'h00, 1'b1, 8'hFF},  // R1 erased
    {5'b01010, 17'h00005, 8'hA5, 1'b0, 8'h00},  // R5 program
    {5'b00110, 17'h00005, 8'h00, 1'b1, 8'hA5},  // R7 verify
    {5'b00100, 17'h00005, 8'h00, 1'b1, 8'hA5},  // R2 read
    {5'b01010, 17'h00005, 8'hF0, 1'b0, 8'h00},  // R6 second write
    {5'b00100, 17'h00005, 8'h00, 1'b1, 8'hA0},  // R6 AND result
    {5'b01010, 17'h00005, 8'hFF, 1'b0, 8'h00},  // R6 try restore
    {5'b00110, 17'h00005, 8'h00, 1'b1, 8'hA0},  // R6 ones stay gone
    {5'b10100, 17'h00005, 8'h00, 1'b0, 8'h00},  // R3 standby
    {5'b11010, 17'h00006, 8'h00, 1'b0, 8'h00},  // R3 inhibit
    {5'b00100, 17'h00006, 8'h00, 1'b1, 8'hFF},  // R3 no write
    {5'b01100, 17'h00006, 8'h00, 1'b0, 8'h00},  // R4 out disable
    {5'b01000, 17'h00007, 8'h00, 1'b0, 8'h00},  // R9 strobe w/o supply
    {5'b00100, 17'h00007, 8'h00, 1'b1, 8'hFF},  // R9 no write
    {5'b00010, 17'h00007, 8'h00, 1'b0, 8'h00},  // R10 conflict
    {5'b00100, 17'h00007, 8'h00, 1'b1, 8'hFF},  // R10 no write
    {5'b00101, 17'h00200, 8'h00, 1'b1, 8'h07},  // R8 maker
    {5'b00101, 17'h00201, 8'h00, 1'b1, 8'h38},  // R8 device
    {5'b01010, 17'h00201, 8'h3C, 1'b0, 8'h00},  // R5 program 0x201
    {5'b00101, 17'h00201, 8'h00, 1'b1, 8'h38},  // R8 id hides array
    {5'b00100, 17'h00201, 8'h00, 1'b1, 8'h3C},  // R8 array intact
    {5'b10110, 17'h00201, 8'h00, 1'b0, 8'h00}   // R11 zero when idle
  };

  task automatic check(input string req, input logic en_exp, input logic [7:0] d_exp);
    checks++;
    if (dout_en !== en_exp || dout !== d_exp) begin
      errors++;
      $display("FAIL %s: en=%b dout=%h expected en=%b dout=%h", req, dout_en, dout, en_exp, d_exp);
    end
  endtask

  task automatic apply(input logic [38:0] v);
    @(negedge clk);
    {ce_n, oe_n, pgm_n, vpp_hi, id_hv} = v[38:34];
    addr = v[33:17];
    din  = v[16:9];
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 1'b0, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("vector %0d", i), VEC[i][8], VEC[i][7:0]);
    end
    // directed: reset erases programmed byte (R1)
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    apply({5'b00100, 17'h00005, 8'h00, 1'b1, 8'hFF});
    check("R1 erased after reset", 1'b1, 8'hFF);
    // directed: top stored address reads erased (R2)
    apply({5'b00100, 17'h007FF, 8'h00, 1'b1, 8'hFF});
    check("R2 read last index", 1'b1, 8'hFF);
    // directed: program a byte to zero, then verify (R5, R7)
    apply({5'b01010, 17'h007FF, 8'h00, 1'b0, 8'h00});
    check("R5 program quiet", 1'b0, 8'h00);
    apply({5'b00110, 17'h007FF, 8'h00, 1'b1, 8'h00});
    check("R7 verify zero", 1'b1, 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule